// File: doc/BRIEF.md
# Transmit Descriptor Status Write-Back Sequencer

This block handles the status write-back step of a transmit DMA engine. That engine may split one outgoing frame across a chain of descriptors. For each descriptor the engine finishes with, it hands the block one completion event. The event carries five things:

- the descriptor's memory address;
- a two-bit frame-position code;
- the cached copy of the descriptor's first 32-bit word;
- the frame's final error flag;
- the frame's final 4-bit status.

The block decides whether that descriptor gets a write-back. When it does, the block builds the new first word and issues it as one 32-bit write on a valid/ready memory write port.

Only descriptors that hold the start or the end of a frame are written back. Middle descriptors are consumed without any memory traffic. Each write-back clears the descriptor's active bit, which tells software that the slot may be reused. The error flag and the status are merged only into the descriptor that holds the frame end.

Events are taken strictly in order, and the next event waits until the current write has been acknowledged. Because of this, a frame's start descriptor is always released before its end descriptor. If a frame-end event arrives with no open frame, it is still written back, and it also sets a sticky sequence-error output.

Top module: `txwb_seq`

## Requirements
- R1: Position code 2'b10 (start) and 2'b11 (whole frame in one descriptor) each produce exactly one memory write for the event.
- R2: Position code 2'b01 (frame end) produces exactly one memory write for the event.
- R3: Position code 2'b00 (middle) is accepted and produces no memory write, including in frames that span three or more descriptors.
- R4: For codes 2'b01 and 2'b11, the written word equals the cached word with three changes: bit 31 (active) cleared, bit 27 set to the error flag, and bits 3:0 set to the status. Every other bit is kept.
- R5: For code 2'b10, the written word equals the cached word with only bit 31 cleared. The error and status inputs have no effect on it.
- R6: The write address equals the address of the event that caused it.
- R7: While a write is pending, evt_ready is low. wr_valid, wr_addr and wr_data hold steady until wr_ready is seen high.
- R8: Writes leave in event order, so a frame's start write precedes its end write.
- R9: A 2'b01 event with no open frame still produces its write and sets seq_err. A frame is open after a 2'b10 and is closed by 2'b01 or 2'b11. seq_err stays high until reset.
- R10: After reset, wr_valid and seq_err are low and evt_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Event accepted on this edge when high together with evt_valid |
| evt_addr | input | ADDR_W | Address of the descriptor's first word |
| evt_pos | input | 2 | Frame-position code: 00 middle, 01 end, 10 start, 11 whole frame |
| evt_word | input | 32 | Cached first descriptor word |
| evt_err | input | 1 | Frame error flag |
| evt_stat | input | 4 | Frame status |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| seq_err | output | 1 | Sticky flag: frame end seen with no open frame |

## Verification
The hardest condition to reach is a pending write that must hold steady while memory stalls, with a frame-end event already waiting behind it. Reaching it requires the memory side to withhold ready exactly while the event side keeps offering.

The bench reaches it by driving wr_ready from three fixed stall patterns. Under each pattern it replays a full sweep of all position codes with every error and status value, followed by chained frames of one to six descriptors. Orphan frame ends arise naturally inside the sweep, so the sticky flag is exercised in the middle of the traffic.

// File: rtl/txwb_pkg.sv
package txwb_pkg;
  localparam int DW      = 32;
  localparam int ACT_BIT = 31;
  localparam int ERR_BIT = 27;
  localparam int STAT_W  = 4;

  typedef enum logic [1:0] {
    POS_MID   = 2'b00,
    POS_END   = 2'b01,
    POS_START = 2'b10,
    POS_WHOLE = 2'b11
  } pos_e;

  function automatic logic holds_end(input logic [1:0] pos);
    return pos[0];
  endfunction

  function automatic logic needs_wb(input logic [1:0] pos);
    return pos != POS_MID;
  endfunction

  function automatic logic [DW-1:0] wb_word(input logic [DW-1:0] w,
                                            input logic [1:0]    pos,
                                            input logic          err,
                                            input logic [STAT_W-1:0] st);
    logic [DW-1:0] r;
    r = w;
    r[ACT_BIT] = 1'b0;
    if (holds_end(pos)) begin
      r[ERR_BIT]      = err;
      r[STAT_W-1:0]   = st;
    end
    return r;
  endfunction
endpackage

// File: rtl/txwb_compose.sv
module txwb_compose
  import txwb_pkg::*;
(
  input  logic [1:0]        pos,
  input  logic [DW-1:0]     word,
  input  logic              err,
  input  logic [STAT_W-1:0] stat,
  output logic              need_wb,
  output logic [DW-1:0]     data
);
  always_comb begin
    need_wb = needs_wb(pos);
    data    = wb_word(word, pos, err, stat);
  end
endmodule

// File: rtl/txwb_track.sv
module txwb_track
  import txwb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [1:0] pos,
  output logic       seq_err
);
  logic in_frame;
  logic orphan_end;

  assign orphan_end = acc && (pos == POS_END) && !in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      if (acc) begin
        if (pos == POS_START)  in_frame <= 1'b1;
        else if (holds_end(pos)) in_frame <= 1'b0;
      end
      if (orphan_end) seq_err <= 1'b1;
    end
  end

  AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err) else $error("seq_err dropped"); // R9
  AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pos == POS_END && !in_frame) |=> seq_err) else $error("orphan end not flagged"); // R9
endmodule

// File: rtl/txwb_wport.sv
module txwb_wport
  import txwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DW-1:0]     load_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data
);
  logic fire;
  assign fire = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= load_addr;
      wr_data  <= load_data;
    end else if (fire) begin
      wr_valid <= 1'b0;
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)))
    else $error("write request changed while stalled"); // R7
endmodule

// File: rtl/txwb_seq.sv
module txwb_seq
  import txwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [1:0]        evt_pos,
  input  logic [31:0]       evt_word,
  input  logic              evt_err,
  input  logic [3:0]        evt_stat,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              seq_err
);
  logic          acc;
  logic          need_wb;
  logic          load;
  logic [DW-1:0] new_word;

  assign evt_ready = !wr_valid;
  assign acc       = evt_valid && evt_ready;
  assign load      = acc && need_wb;

  txwb_compose u_compose (
    .pos     (evt_pos),
    .word    (evt_word),
    .err     (evt_err),
    .stat    (evt_stat),
    .need_wb (need_wb),
    .data    (new_word)
  );

  txwb_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .pos     (evt_pos),
    .seq_err (seq_err)
  );

  txwb_wport #(.ADDR_W(ADDR_W)) u_wport (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (evt_addr),
    .load_data (new_word),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  AST_MID_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && evt_pos == POS_MID) |=> !wr_valid) else $error("middle descriptor written"); // R3
  AST_EDGE_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && evt_pos != POS_MID) |=> (wr_valid && wr_addr == $past(evt_addr)))
    else $error("start/end descriptor not written"); // R1 R2 R6
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !evt_ready) else $error("event accepted during pending write"); // R7
  AST_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_data[ACT_BIT]) else $error("active bit left set"); // R4 R5
endmodule

// File: tb/txwb_seq_test.sv
`timescale 1ns/1ps
module txwb_seq_test;
  localparam int ADDR_W  = 32;
  localparam int CLK_P   = 16;
  localparam int DRV_DLY = CLK_P / 8;
  localparam int MON_DLY = 3 * CLK_P / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evt_valid = 1'b0;
  logic              evt_ready;
  logic [ADDR_W-1:0] evt_addr = '0;
  logic [1:0]        evt_pos = 2'b00;
  logic [31:0]       evt_word = '0;
  logic              evt_err = 1'b0;
  logic [3:0]        evt_stat = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              seq_err;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int cyc = 0;
  int writes_seen = 0;
  int writes_exp = 0;
  bit done = 0;
  bit model_open = 0;
  bit model_seq = 0;
  logic [ADDR_W-1:0] q_addr[$];
  logic [31:0]       q_data[$];

  txwb_seq #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_addr(evt_addr), .evt_pos(evt_pos), .evt_word(evt_word),
    .evt_err(evt_err), .evt_stat(evt_stat), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .seq_err(seq_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input logic [1:0] p,
                                              input logic e, input logic [3:0] s);
    logic [31:0] keep_mask;
    if (p == 2'b10) return w & 32'h7FFF_FFFF;
    keep_mask = ~(32'h8000_0000 | 32'h0800_0000 | 32'h0000_000F);
    return (w & keep_mask) | ({31'd0, e} << 27) | {28'd0, s};
  endfunction

  // ready pattern on memory side
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (mode)
        0: wr_ready = 1'b1;
        1: wr_ready = (cyc % 3) != 0;
        default: wr_ready = (cyc % 5) == 4;
      endcase
    end
  end

  // monitor of the write port
  initial begin
    bit hold_prev = 0;
    logic [ADDR_W-1:0] pa;
    logic [31:0] pd;
    forever begin
      @(negedge clk);
      #(MON_DLY);
      if (rst_n) begin
        check(evt_ready == !wr_valid, "R7 ready while pending", evt_ready, !wr_valid);
        if (hold_prev)
          check(wr_valid && wr_addr == pa && wr_data == pd, "R7 hold under stall",
                {wr_addr, wr_data}, {pa, pd});
        if (wr_valid && wr_ready) begin
          writes_seen++;
          if (q_addr.size() == 0) begin
            check(0, "R3 unexpected write", wr_addr, 0);
          end else begin
            logic [ADDR_W-1:0] ea;
            logic [31:0] ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            check(wr_addr == ea, "R6 R8 write address", wr_addr, ea);
            check(wr_data == ed, "R4 R5 write data", wr_data, ed);
          end
        end
        hold_prev = wr_valid && !wr_ready;
        pa = wr_addr;
        pd = wr_data;
      end else begin
        hold_prev = 0;
      end
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a, input logic [1:0] p,
                      input logic [31:0] w, input logic e, input logic [3:0] s);
    bit got;
    got = 0;
    @(negedge clk);
    evt_addr = a; evt_pos = p; evt_word = w; evt_err = e; evt_stat = s;
    evt_valid = 1'b1;
    while (!got) begin
      #(DRV_DLY);
      got = evt_ready;
      @(negedge clk);
    end
    evt_valid = 1'b0;
    if (p == 2'b01 && !model_open) model_seq = 1;
    if (p == 2'b10) model_open = 1;
    else if (p[0]) model_open = 0;
    if (p != 2'b00) begin
      q_addr.push_back(a);
      q_data.push_back(expect_word(w, p, e, s));
      writes_exp++;
    end
    #(DRV_DLY);
    check(seq_err == model_seq, "R9 sequence flag", seq_err, model_seq);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_open = 0;
    model_seq = 0;
    q_addr.delete();
    q_data.delete();
    #(MON_DLY);
    check(!wr_valid && !seq_err && evt_ready, "R10 reset state",
          {wr_valid, seq_err, evt_ready}, 3'b001);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((q_addr.size() != 0 || wr_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    #(MON_DLY);
    check(q_addr.size() == 0, "R1 R2 all writes issued", q_addr.size(), 0);
  endtask

  initial begin
    do_reset();
    for (int m = 0; m < 3; m++) begin
      mode = m;
      // sweep of every code, error and status (orphans occur naturally)
      for (int i = 0; i < 128; i++) begin
        logic [31:0] w;
        w = 32'hA5C3_0F0F ^ (i * 32'h0101_0101) ^ (m << 9);
        send(32'h1000_0000 + i * 16, i[6:5], w | 32'h8000_0000, i[4], i[3:0]);
      end
      drain();
      // chained frames of length 1..6 (R3 middles, R8 ordering)
      for (int n = 1; n <= 6; n++) begin
        for (int d = 0; d < n; d++) begin
          logic [1:0] p;
          if (n == 1) p = 2'b11;
          else if (d == 0) p = 2'b10;
          else if (d == n - 1) p = 2'b01;
          else p = 2'b00;
          send(32'h2000_0000 + n * 256 + d * 16, p, 32'hFFFF_FFFF - d, n[0], 4'(n + d));
        end
      end
      drain();
    end
    check(writes_seen == writes_exp, "R3 write count", writes_seen, writes_exp);
    // seq_err held until reset, then cleared
    check(seq_err == 1'b1, "R9 sticky", seq_err, 1);
    do_reset();
    // orphan end right after reset still written and flagged
    send(32'h3000_0000, 2'b01, 32'h8000_0000, 1'b1, 4'h5);
    drain();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule